// File: doc/BRIEF.md
# Prioritised Device Power State Controller

This block is the fixed power-state sequencer of a power-management device. It takes qualified status flags (main supply good, backup source present, shelf-mode enable, off and wake requests, configuration-load and self-test results, error flags) and decides which power state the device sits in. It issues one-cycle start strobes to the configuration loader and the self-test engine. It drives the regulator-enable signal, which is high only when the device has reached its active operating state.

Several conditions can be true at once. The next state is then chosen by a fixed ranking: supply loss beats everything, error recovery beats low-power standby, and standby beats normal operation. A bounded retry counter limits how many times the device may restart from the recovery state. Once the limit is used up, the device stays in recovery until the main supply goes away and comes back.

All flag inputs pass through a two-stage synchroniser before the state logic sees them.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset `state_o` is 0 (unpowered), and `reg_en`, `cfg_load` and `test_start` are 0. The state codes are: 0 unpowered, 1 battery hold, 2 low-power standby, 3 configuration, 4 boot self-test, 5 runtime self-test, 6 recovery, 7 active.
- R2: When `supply_ok` is low, the next state is 1 if `backup_ok` is high and `shelf_en` is low, and 0 otherwise. This holds from any state and overrides every other input.
- R3: From state 0 or 1 with `supply_ok` high, the machine enters state 3. In the same cycle it raises `cfg_load` for exactly one cycle.
- R4: State 3 waits for `cfg_done` and then enters state 4, raising `test_start` for one cycle.
- R5: In state 4 or 5, `test_done` with `test_pass` high leads to state 7, and `test_done` with `test_pass` low leads to state 6. State 7 is entered from no other state.
- R6: `reg_en` is high exactly when `state_o` is 7.
- R7: In state 7, `off_req` or `bus_off_req` moves to state 2 only when `stby_sel` is 1. With `stby_sel` at 0 the request is ignored and the state stays 7.
- R8: In state 2, any of `wake_pin`, `on_req` or `rtc_wake` moves the machine to state 3. Without one of them it stays in state 2.
- R9: `err_qual` moves states 2, 3, 4, 5 and 7 to state 6. In state 7 it takes priority over an off request and a test request.
- R10: In state 7, `test_req` moves to state 5 with a one-cycle `test_start`. `reg_en` falls on that entry.
- R11: In state 6, `err_clear` returns to state 3 and increments the retry count, as long as the count is below `CNT_MAX`. With the count at `CNT_MAX` the machine stays in state 6 whatever `err_clear` does.
- R12: The retry count is cleared whenever the machine is in state 0 or 1. After the supply is cycled, restarts from state 6 are allowed again.
- R13: An input change that is set up before clock edge k shows in `state_o` after edge k+2. This is the latency of the two synchroniser stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Main supply at or above its under-voltage level |
| backup_ok | input | 1 | Backup source present and in range |
| shelf_en | input | 1 | Shelf mode: skip battery hold on supply loss |
| off_req | input | 1 | Off request from the control pin |
| bus_off_req | input | 1 | Off trigger issued over the host bus |
| on_req | input | 1 | On request |
| wake_pin | input | 1 | Low-power wake pin event |
| rtc_wake | input | 1 | Alarm or timer wake from the real-time clock |
| stby_sel | input | 1 | Off requests lead to standby when 1 |
| cfg_done | input | 1 | Default configuration load finished |
| test_req | input | 1 | Runtime self-test request |
| test_done | input | 1 | Self-test finished |
| test_pass | input | 1 | Self-test result, valid with test_done |
| err_qual | input | 1 | Qualified error requiring shutdown |
| err_clear | input | 1 | Error has recovered |
| state_o | output | 3 | Current power state code |
| reg_en | output | 1 | Regulator enable drive |
| cfg_load | output | 1 | One-cycle start strobe for configuration load |
| test_start | output | 1 | One-cycle start strobe for self-test |

## Verification
A wrong state register shows on `state_o` in the same cycle, and `reg_en` follows it in lockstep. A machine that wrongly reaches or leaves state 7 therefore toggles the regulator drive at once. A wrong retry count stays hidden until the restart that crosses the limit. It then shows as an extra return to state 3, or as a lock one restart too early. The bench reaches that point by sweeping every restart up to one past the limit. It also sweeps every combination of supply, backup and shelf flags while all lower-ranked requests are asserted.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

    typedef enum logic [2:0] {
        PS_UNPOWERED  = 3'd0,
        PS_BATT_HOLD  = 3'd1,
        PS_LOWPWR     = 3'd2,
        PS_CONFIG     = 3'd3,
        PS_BOOT_CHECK = 3'd4,
        PS_LIVE_CHECK = 3'd5,
        PS_RECOVERY   = 3'd6,
        PS_ACTIVE     = 3'd7
    } pwr_state_e;

    typedef struct packed {
        logic supply_ok;
        logic backup_ok;
        logic shelf_en;
        logic off_req;
        logic bus_off_req;
        logic on_req;
        logic wake_pin;
        logic rtc_wake;
        logic stby_sel;
        logic cfg_done;
        logic test_req;
        logic test_done;
        logic test_pass;
        logic err_qual;
        logic err_clear;
    } pwr_in_t;

    localparam int IN_W = $bits(pwr_in_t);

    function automatic logic is_powered_down(pwr_state_e s);
        return (s == PS_UNPOWERED) || (s == PS_BATT_HOLD);
    endfunction

    function automatic logic is_check_state(pwr_state_e s);
        return (s == PS_BOOT_CHECK) || (s == PS_LIVE_CHECK);
    endfunction

    function automatic logic any_wake(pwr_in_t f);
        return f.wake_pin | f.on_req | f.rtc_wake;
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_next_state.sv
module pwr_next_state
    import pwr_state_pkg::*;
(
    input  pwr_state_e cur,
    input  pwr_in_t    flags,
    input  logic       retry_ok,
    output pwr_state_e nxt
);
    always_comb begin
        nxt = cur;
        if (!flags.supply_ok) begin
            // supply loss ranks highest
            nxt = (flags.backup_ok && !flags.shelf_en) ? PS_BATT_HOLD : PS_UNPOWERED;
        end else if (is_powered_down(cur)) begin
            nxt = PS_CONFIG;
        end else if (cur == PS_RECOVERY) begin
            if (flags.err_clear && retry_ok) begin
                nxt = PS_CONFIG;
            end
        end else if (flags.err_qual) begin
            nxt = PS_RECOVERY;
        end else begin
            unique case (cur)
                PS_LOWPWR: begin
                    if (any_wake(flags)) nxt = PS_CONFIG;
                end
                PS_CONFIG: begin
                    if (flags.cfg_done) nxt = PS_BOOT_CHECK;
                end
                PS_BOOT_CHECK, PS_LIVE_CHECK: begin
                    if (flags.test_done) nxt = flags.test_pass ? PS_ACTIVE : PS_RECOVERY;
                end
                PS_ACTIVE: begin
                    if ((flags.off_req || flags.bus_off_req) && flags.stby_sel) begin
                        nxt = PS_LOWPWR;
                    end else if (flags.test_req) begin
                        nxt = PS_LIVE_CHECK;
                    end
                end
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/pwr_retry_ctr.sv
module pwr_retry_ctr
    import pwr_state_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  pwr_state_e       cur,
    input  pwr_state_e       nxt,
    output logic [CNT_W-1:0] cnt,
    output logic             retry_ok
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (is_powered_down(nxt)) begin
            cnt <= '0;
        end else if (cur == PS_RECOVERY && nxt == PS_CONFIG) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // lock is implied: at the limit no further restart is granted
    assign retry_ok = (cnt < LIMIT);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int CNT_MAX     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       backup_ok,
    input  logic       shelf_en,
    input  logic       off_req,
    input  logic       bus_off_req,
    input  logic       on_req,
    input  logic       wake_pin,
    input  logic       rtc_wake,
    input  logic       stby_sel,
    input  logic       cfg_done,
    input  logic       test_req,
    input  logic       test_done,
    input  logic       test_pass,
    input  logic       err_qual,
    input  logic       err_clear,
    output logic [2:0] state_o,
    output logic       reg_en,
    output logic       cfg_load,
    output logic       test_start
);
    pwr_in_t          raw_in;
    logic [IN_W-1:0]  sync_q;
    pwr_in_t          flags;
    pwr_state_e       cur_state;
    pwr_state_e       nxt_state;
    logic [CNT_W-1:0] retry_cnt;
    logic             retry_ok;

    always_comb begin
        raw_in             = '0;
        raw_in.supply_ok   = supply_ok;
        raw_in.backup_ok   = backup_ok;
        raw_in.shelf_en    = shelf_en;
        raw_in.off_req     = off_req;
        raw_in.bus_off_req = bus_off_req;
        raw_in.on_req      = on_req;
        raw_in.wake_pin    = wake_pin;
        raw_in.rtc_wake    = rtc_wake;
        raw_in.stby_sel    = stby_sel;
        raw_in.cfg_done    = cfg_done;
        raw_in.test_req    = test_req;
        raw_in.test_done   = test_done;
        raw_in.test_pass   = test_pass;
        raw_in.err_qual    = err_qual;
        raw_in.err_clear   = err_clear;
    end

    pwr_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_q)
    );

    assign flags = pwr_in_t'(sync_q);

    pwr_next_state u_next (
        .cur      (cur_state),
        .flags    (flags),
        .retry_ok (retry_ok),
        .nxt      (nxt_state)
    );

    pwr_retry_ctr #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_retry (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur_state),
        .nxt      (nxt_state),
        .cnt      (retry_cnt),
        .retry_ok (retry_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state  <= PS_UNPOWERED;
            reg_en     <= 1'b0;
            cfg_load   <= 1'b0;
            test_start <= 1'b0;
        end else begin
            cur_state  <= nxt_state;
            reg_en     <= (nxt_state == PS_ACTIVE);
            cfg_load   <= (nxt_state == PS_CONFIG) && (cur_state != PS_CONFIG);
            test_start <= is_check_state(nxt_state) && (nxt_state != cur_state);
        end
    end

    assign state_o = cur_state;
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk
    import pwr_state_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       state_o,
    input logic             reg_en,
    input logic             cfg_load,
    input logic             test_start,
    input logic [CNT_W-1:0] rcnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

    p_regen_active_r6: assert property (@(posedge clk) disable iff (rst)
        reg_en == (state_o == PS_ACTIVE));

    p_cfg_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_load |-> (state_o == PS_CONFIG) && ($past(state_o) != PS_CONFIG));

    p_cfg_entry_r3: assert property (@(posedge clk) disable iff (rst)
        ((state_o == PS_CONFIG) && ($past(state_o) != PS_CONFIG)) |-> cfg_load);

    p_test_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        test_start |-> ((state_o == PS_BOOT_CHECK) || (state_o == PS_LIVE_CHECK))
                       && ($past(state_o) != state_o));

    p_active_source_r5: assert property (@(posedge clk) disable iff (rst)
        ((state_o == PS_ACTIVE) && ($past(state_o) != PS_ACTIVE)) |->
        (($past(state_o) == PS_BOOT_CHECK) || ($past(state_o) == PS_LIVE_CHECK)));

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
        rcnt <= LIMIT);

    p_retry_step_r11: assert property (@(posedge clk) disable iff (rst)
        (($past(state_o) == PS_RECOVERY) && (state_o == PS_CONFIG)) |->
        (rcnt == $past(rcnt) + CNT_W'(1)));

    p_cnt_clear_r12: assert property (@(posedge clk) disable iff (rst)
        ((state_o == PS_UNPOWERED) || (state_o == PS_BATT_HOLD)) |-> (rcnt == '0));
endmodule

bind pwr_state_ctrl pwr_state_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_o    (state_o),
    .reg_en     (reg_en),
    .cfg_load   (cfg_load),
    .test_start (test_start),
    .rcnt       (retry_cnt)
);

// File: tb/test_pwr_state_ctrl.sv
`timescale 1ns/1ps
module test_pwr_state_ctrl;
    localparam int BMAX = 3;
    localparam int S_OFF = 0, S_BATT = 1, S_LOW = 2, S_CFG = 3,
                   S_BOOT = 4, S_LIVE = 5, S_REC = 6, S_ACT = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok, backup_ok, shelf_en, off_req, bus_off_req, on_req;
    logic wake_pin, rtc_wake, stby_sel, cfg_done, test_req, test_done;
    logic test_pass, err_qual, err_clear;
    logic [2:0] state_o;
    logic reg_en, cfg_load, test_start;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_state_ctrl #(.CNT_W(4), .CNT_MAX(BMAX), .SYNC_STAGES(2)) i_pwr_state_ctrl (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .backup_ok(backup_ok),
        .shelf_en(shelf_en), .off_req(off_req), .bus_off_req(bus_off_req),
        .on_req(on_req), .wake_pin(wake_pin), .rtc_wake(rtc_wake),
        .stby_sel(stby_sel), .cfg_done(cfg_done), .test_req(test_req),
        .test_done(test_done), .test_pass(test_pass), .err_qual(err_qual),
        .err_clear(err_clear), .state_o(state_o), .reg_en(reg_en),
        .cfg_load(cfg_load), .test_start(test_start)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_in();
        supply_ok = 0; backup_ok = 0; shelf_en = 0; off_req = 0; bus_off_req = 0;
        on_req = 0; wake_pin = 0; rtc_wake = 0; stby_sel = 0; cfg_done = 0;
        test_req = 0; test_done = 0; test_pass = 0; err_qual = 0; err_clear = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clr_in();
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    // from state 3 to state 7 through a passing boot self-test
    task automatic cfg_to_active();
        cfg_done = 1;
        step(3);
        chk("R4 boot check entry", state_o, S_BOOT);
        chk("R4 test_start strobe", test_start, 1);
        cfg_done = 0;
        test_done = 1; test_pass = 1;
        step(3);
        chk("R5 pass to active", state_o, S_ACT);
        chk("R6 reg_en in active", reg_en, 1);
        test_done = 0; test_pass = 0;
    endtask

    task automatic to_active();
        supply_ok = 1;
        step(3);
        chk("R3 config entry", state_o, S_CFG);
        chk("R3 cfg_load strobe", cfg_load, 1);
        cfg_to_active();
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R13 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clr_in();
        step(3);
        // R1 state during and after reset
        chk("R1 reset state", state_o, S_OFF);
        chk("R1 reset reg_en", reg_en, 0);
        rst = 1'b0;
        step(1);
        chk("R1 idle state", state_o, S_OFF);
        chk("R1 idle cfg_load", cfg_load, 0);
        chk("R1 idle test_start", test_start, 0);

        // R13 latency, R3 strobe width
        supply_ok = 1;
        step(2);
        chk("R13 no change after two edges", state_o, S_OFF);
        step(1);
        chk("R13 change on third edge", state_o, S_CFG);
        chk("R3 cfg_load high", cfg_load, 1);
        step(1);
        chk("R3 cfg_load one cycle", cfg_load, 0);
        step(4);
        chk("R4 config waits for cfg_done", state_o, S_CFG);
        cfg_to_active();
        step(1);
        chk("R4 test_start one cycle", test_start, 0);

        // R2 backup / shelf from unpowered
        do_reset();
        backup_ok = 1;
        step(3);
        chk("R2 backup hold", state_o, S_BATT);
        shelf_en = 1;
        step(3);
        chk("R2 shelf skips hold", state_o, S_OFF);
        shelf_en = 0;
        step(3);
        chk("R2 hold again", state_o, S_BATT);
        supply_ok = 1;
        step(3);
        chk("R3 from hold to config", state_o, S_CFG);

        // R2/R9 sweep of supply flags with all lower requests asserted
        for (int c = 0; c < 8; c++) begin
            int exp_s;
            do_reset();
            to_active();
            supply_ok = c[0]; backup_ok = c[1]; shelf_en = c[2];
            err_qual = 1; off_req = 1; stby_sel = 1; test_req = 1;
            step(3);
            if (!c[0]) exp_s = (c[1] && !c[2]) ? S_BATT : S_OFF;
            else exp_s = S_REC;
            chk("R2 R9 priority sweep", state_o, exp_s);
            chk("R6 reg_en off after sweep", reg_en, 0);
        end

        // R5 failing boot test
        do_reset();
        supply_ok = 1;
        step(3);
        cfg_done = 1;
        step(3);
        cfg_done = 0;
        test_done = 1; test_pass = 0;
        step(3);
        chk("R5 boot fail to recovery", state_o, S_REC);
        chk("R6 reg_en low in recovery", reg_en, 0);

        // R7 standby selection, R8 wake sources
        do_reset();
        to_active();
        off_req = 1;
        step(6);
        chk("R7 off ignored without stby_sel", state_o, S_ACT);
        chk("R7 reg_en kept", reg_en, 1);
        stby_sel = 1;
        step(3);
        chk("R7 off to standby", state_o, S_LOW);
        chk("R6 reg_en low in standby", reg_en, 0);
        off_req = 0;
        step(5);
        chk("R8 standby holds without wake", state_o, S_LOW);
        wake_pin = 1;
        step(3);
        chk("R8 wake pin", state_o, S_CFG);
        wake_pin = 0;
        cfg_to_active();
        bus_off_req = 1;
        step(3);
        chk("R7 bus off to standby", state_o, S_LOW);
        bus_off_req = 0;
        on_req = 1;
        step(3);
        chk("R8 on request", state_o, S_CFG);
        on_req = 0;
        cfg_to_active();
        off_req = 1;
        step(3);
        chk("R7 off again", state_o, S_LOW);
        off_req = 0;
        rtc_wake = 1;
        step(3);
        chk("R8 rtc wake", state_o, S_CFG);
        rtc_wake = 0;
        cfg_to_active();
        off_req = 1;
        step(3);
        off_req = 0;
        err_qual = 1;
        step(3);
        chk("R9 error from standby", state_o, S_REC);
        err_qual = 0;

        // R10 runtime self-test
        do_reset();
        to_active();
        test_req = 1;
        step(3);
        chk("R10 runtime check entry", state_o, S_LIVE);
        chk("R10 test_start", test_start, 1);
        chk("R10 reg_en falls", reg_en, 0);
        test_req = 0;
        step(1);
        chk("R10 test_start one cycle", test_start, 0);
        test_done = 1; test_pass = 1;
        step(3);
        chk("R5 runtime pass", state_o, S_ACT);
        test_done = 0; test_pass = 0;
        test_req = 1;
        step(3);
        test_req = 0;
        test_done = 1; test_pass = 0;
        step(3);
        chk("R5 runtime fail", state_o, S_REC);
        test_done = 0;

        // R11 restart limit sweep
        do_reset();
        to_active();
        err_qual = 1;
        step(3);
        chk("R9 error from active", state_o, S_REC);
        for (int k = 1; k <= BMAX + 1; k++) begin
            err_qual = 0;
            err_clear = 1;
            step(3);
            chk("R11 restart sweep", state_o, (k <= BMAX) ? S_CFG : S_REC);
            err_clear = 0;
            if (k <= BMAX) begin
                err_qual = 1;
                step(3);
                chk("R9 error from config", state_o, S_REC);
            end
        end
        err_clear = 1;
        step(20);
        chk("R11 locked in recovery", state_o, S_REC);
        chk("R11 reg_en low when locked", reg_en, 0);
        err_clear = 0;

        // R12 supply cycle releases the lock
        supply_ok = 0;
        step(3);
        chk("R12 supply loss", state_o, S_OFF);
        supply_ok = 1;
        step(3);
        chk("R12 power back", state_o, S_CFG);
        err_qual = 1;
        step(3);
        err_qual = 0;
        err_clear = 1;
        step(3);
        chk("R12 restart allowed after cycle", state_o, S_CFG);
        err_clear = 0;
        step(2);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule